// File: doc/BRIEF.md
# Two-Bank Interrupt Identity Controller

The controller collects 16-bit cause vectors from a set of interrupt sources and sorts them into two banks of pending bits, one bit per source. A summary register shows which banks hold work, and a single interrupt line rises while any bank does. Software services a bank in a fixed order. It reads the bank's pending word, which locks the bank. It writes a one-hot value to the bank's selector. After a fixed latency it reads an identity word that names the source's class and instance and carries the accumulated causes. It acknowledges the identity. Finally it writes the pending bits back to clear them and to unlock the bank.

Sources are numbered globally, and bank b bit i is source g = b*NSRC + i. Each source has its own cause store that ORs in every recorded cause until a completed selection moves the causes into the identity word. Enable and mask words cover two sources each. Causes that arrive while a bank is locked go into a shadow word, so none are lost, and the shadow word is merged into the pending word when the bank unlocks. All register reads return their data one cycle after the read strobe.

The register map uses word addresses: 0 summary, 1+b pending, 3+b selector, 5+b identity, 64+k enable word of pair k, 128+k mask word of pair k.

Top module: `irq_id_ctrl`

## Requirements
- R1: After reset, the summary, pending, selector, identity and enable words read 0, every mask word reads all ones, and `irq_o` is low.
- R2: Pair k covers source 2k in bits [15:0] and source 2k+1 in bits [31:16] of its enable and mask words. A cause bit is recorded only if its enable bit is 1 and its mask bit is 0. A source with nothing recorded does not become pending.
- R3: A recorded cause sets the source's pending bit. Summary bit b is 1 while bank b's pending word is nonzero, and `irq_o` is the OR of the summary bits.
- R4: A selector write to a locked bank whose value is one-hot and hits a pending bit causes the identity word to read {bit31=1, bits30:25=0, bits24:22=g/SPC, bits21:16=g%SPC, bits15:0=causes} LAT cycles after the write.
- R5: Before the identity word becomes valid it reads 0. A selector write to an unlocked bank, or one that is not one-hot, or one that hits no pending bit, leaves the identity reading 0.
- R6: Writing the identity word with bit 31 set while it is valid clears it to 0 and marks the selected source as served.
- R7: A write to a pending word clears (write-1-to-clear) only those written bits whose source has been served. Bits written back without service stay set.
- R8: Reading a pending word locks the bank. While the bank is locked its pending word does not change, and new causes wait in the shadow word. Any write to the pending word unlocks the bank and merges the shadow word into it.
- R9: Causes that arrive at the same source before it is selected accumulate by OR into one identity.
- R10: A selector write is ignored while a selection is in flight or the identity is valid. A valid identity holds until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_cause_i | input | 2*NSRC*16 | Cause vector of source g in bits [16g+15:16g], sampled every cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered one cycle after the read strobe |
| irq_o | output | 1 | High while any bank has a pending bit |

## Verification
A cause held for one cycle is recorded at that edge. A pending or summary read one cycle later sees it, because the read data is registered at the read edge. The identity register is loaded on the LAT-th edge after the selector write edge. The bench issues reads on consecutive cycles from the first edge after the write. It expects 0 from the first LAT reads and the full word from read LAT+1, so data-valid is checked at exactly the due cycle and not just eventually. An acknowledge, a pending write or an unlock takes effect at its own edge, and the bench checks it with the next read.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
  localparam int CAUSE_W = 16;
  localparam int A_MASTER = 0;
  localparam int A_PEND   = 1;
  localparam int A_SEL    = 3;
  localparam int A_IDENT  = 5;
  localparam int A_EN     = 64;
  localparam int A_MASK   = 128;
  localparam int VALID_BIT = 31;

  function automatic logic [31:0] ident_word(input int g, input int spc,
                                             input logic [CAUSE_W-1:0] c);
    logic [2:0] cls;
    logic [5:0] inst;
    cls  = 3'(g / spc);
    inst = 6'(g % spc);
    return {1'b1, 6'b0, cls, inst, c};
  endfunction
endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate import irq_id_pkg::*; #(
  parameter int NPAIR = 32
) (
  input  logic [2*NPAIR-1:0][CAUSE_W-1:0] cause_i,
  input  logic [NPAIR-1:0][31:0]          en_i,
  input  logic [NPAIR-1:0][31:0]          mask_i,
  output logic [2*NPAIR-1:0][CAUSE_W-1:0] gated_o
);
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign gated_o[2*k]   = cause_i[2*k]   & en_i[k][15:0]  & ~mask_i[k][15:0];
    assign gated_o[2*k+1] = cause_i[2*k+1] & en_i[k][31:16] & ~mask_i[k][31:16];
  end
endmodule

// File: rtl/irq_id_bank.sv
module irq_id_bank import irq_id_pkg::*; #(
  parameter int NSRC = 32,
  parameter int LAT  = 4,
  parameter int BANK = 0,
  parameter int SPC  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSRC-1:0][CAUSE_W-1:0]  cause_i,
  input  logic                          pend_rd_i,
  input  logic                          pend_wr_i,
  input  logic                          sel_wr_i,
  input  logic                          id_wr_i,
  input  logic [31:0]                   wdata_i,
  output logic [NSRC-1:0]               pend_o,
  output logic [NSRC-1:0]               done_o,
  output logic [NSRC-1:0]               sel_o,
  output logic                          locked_o,
  output logic [31:0]                   id_o
);
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CNTW = $clog2(LAT + 1);

  logic [NSRC-1:0][CAUSE_W-1:0] store_q, store_n;
  logic [NSRC-1:0] pend_q, shd_q, done_q, sel_q, hit, keep, clr, done_set, wmask;
  logic            lock_q, ok_q, capture, take, ack, sel_acc, sel_good;
  logic [CNTW-1:0] cnt_q;
  logic [31:0]     id_q;
  logic [IW-1:0]   sel_idx;

  assign wmask = wdata_i[NSRC-1:0];

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (sel_q[i]) sel_idx = IW'(i);
  end

  assign capture  = (cnt_q == CNTW'(1));
  assign take     = capture && ok_q && pend_q[sel_idx];
  assign ack      = id_wr_i && wdata_i[VALID_BIT] && id_q[VALID_BIT];
  assign done_set = ack ? sel_q : '0;
  assign sel_acc  = sel_wr_i && (cnt_q == '0) && !id_q[VALID_BIT];
  assign sel_good = lock_q && $onehot(wmask) && (|(wmask & pend_q)) &&
                    ((wdata_i >> NSRC) == 32'd0);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i]     = |cause_i[i];
    assign store_n[i] = ((take && sel_idx == IW'(i)) ? '0 : store_q[i]) | cause_i[i];
    assign keep[i]    = |store_n[i];
  end

  assign clr = pend_wr_i ? (wmask & done_q & ~keep) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
      pend_q  <= '0;
      shd_q   <= '0;
      done_q  <= '0;
      lock_q  <= 1'b0;
    end else begin
      store_q <= store_n;
      if (pend_wr_i) begin
        pend_q <= (pend_q & ~clr) | shd_q | hit;
        shd_q  <= '0;
        lock_q <= 1'b0;
        done_q <= (done_q & ~wmask) | done_set;
      end else begin
        done_q <= done_q | done_set;
        if (lock_q) shd_q <= shd_q | hit;
        else begin
          pend_q <= pend_q | hit;
          if (pend_rd_i) lock_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      ok_q  <= 1'b0;
      cnt_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_acc) begin
        sel_q <= wmask;
        ok_q  <= sel_good;
        cnt_q <= CNTW'(LAT);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNTW'(1);
      end
      if (ack) id_q <= '0;
      else if (take) id_q <= ident_word(BANK * NSRC + int'(sel_idx), SPC, store_q[sel_idx]);
    end
  end

  assign pend_o   = pend_q;
  assign done_o   = done_q;
  assign sel_o    = sel_q;
  assign locked_o = lock_q;
  assign id_o     = id_q;
endmodule

// File: rtl/irq_id_ctrl.sv
module irq_id_ctrl import irq_id_pkg::*; #(
  parameter int NSRC = 32,
  parameter int LAT  = 4,
  parameter int SPC  = 8,
  parameter int AW   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*NSRC*CAUSE_W-1:0] src_cause_i,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [AW-1:0]             reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic                      irq_o
);
  localparam int NPAIR = NSRC;
  localparam int NTOT  = 2 * NSRC;

  logic [NPAIR-1:0][31:0]        en_q, mask_q;
  logic [NTOT-1:0][CAUSE_W-1:0]  cause_all, gated;
  logic [1:0][NSRC-1:0]          pend_b, done_b, sel_b;
  logic [1:0][31:0]              id_b;
  logic [1:0]                    lock_b, pend_rd, pend_wr, sel_wr, id_wr, master;

  assign cause_all = src_cause_i;

  irq_src_gate #(.NPAIR(NPAIR)) u_gate (
    .cause_i(cause_all), .en_i(en_q), .mask_i(mask_q), .gated_o(gated)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign pend_rd[b] = reg_rd_i && (reg_addr_i == AW'(A_PEND + b));
    assign pend_wr[b] = reg_wr_i && (reg_addr_i == AW'(A_PEND + b));
    assign sel_wr[b]  = reg_wr_i && (reg_addr_i == AW'(A_SEL + b));
    assign id_wr[b]   = reg_wr_i && (reg_addr_i == AW'(A_IDENT + b));
    assign master[b]  = |pend_b[b];

    irq_id_bank #(.NSRC(NSRC), .LAT(LAT), .BANK(b), .SPC(SPC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cause_i(gated[b*NSRC +: NSRC]),
      .pend_rd_i(pend_rd[b]), .pend_wr_i(pend_wr[b]),
      .sel_wr_i(sel_wr[b]), .id_wr_i(id_wr[b]),
      .wdata_i(reg_wdata_i),
      .pend_o(pend_b[b]), .done_o(done_b[b]), .sel_o(sel_b[b]),
      .locked_o(lock_b[b]), .id_o(id_b[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '1;
    end else if (reg_wr_i) begin
      for (int k = 0; k < NPAIR; k++) begin
        if (reg_addr_i == AW'(A_EN + k))   en_q[k]   <= reg_wdata_i;
        if (reg_addr_i == AW'(A_MASK + k)) mask_q[k] <= reg_wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata_o <= '0;
    else if (reg_rd_i) begin
      reg_rdata_o <= '0;
      if (reg_addr_i == AW'(A_MASTER)) reg_rdata_o <= {30'b0, master};
      for (int b = 0; b < 2; b++) begin
        if (reg_addr_i == AW'(A_PEND + b))  reg_rdata_o <= 32'(pend_b[b]);
        if (reg_addr_i == AW'(A_SEL + b))   reg_rdata_o <= 32'(sel_b[b]);
        if (reg_addr_i == AW'(A_IDENT + b)) reg_rdata_o <= id_b[b];
      end
      for (int k = 0; k < NPAIR; k++) begin
        if (reg_addr_i == AW'(A_EN + k))   reg_rdata_o <= en_q[k];
        if (reg_addr_i == AW'(A_MASK + k)) reg_rdata_o <= mask_q[k];
      end
    end
  end

  assign irq_o = |master;
endmodule

// File: rtl/irq_id_checker.sv
module irq_id_checker #(
  parameter int NSRC = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           pend_wr,
  input logic [1:0]           id_wr,
  input logic [31:0]          wdata,
  input logic [1:0][NSRC-1:0] pend,
  input logic [1:0][NSRC-1:0] done,
  input logic [1:0][NSRC-1:0] sel,
  input logic [1:0]           lock,
  input logic [1:0][31:0]     id
);
  for (genvar b = 0; b < 2; b++) begin : g_chk
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (lock[b] && !pend_wr[b]) |=> $stable(pend[b])); // R8
    AST_SERVED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(pend[b]) & ~pend[b]) & ~$past(done[b])) == '0)); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (id_wr[b] && wdata[31] && id[b][31]) |=> (id[b] == 32'd0)); // R6
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (id[b][31] && !(id_wr[b] && wdata[31])) |=> $stable(id[b])); // R10
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id[b][31]) |-> $onehot(sel[b])); // R4
  end
endmodule

bind irq_id_ctrl irq_id_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_wr(pend_wr), .id_wr(id_wr),
  .wdata(reg_wdata_i), .pend(pend_b), .done(done_b), .sel(sel_b),
  .lock(lock_b), .id(id_b)
);

// File: tb/tb_irq_id_ctrl.sv
module tb_irq_id_ctrl;
  localparam int CLK_P = 10;
  localparam int NSRC  = 4;
  localparam int LAT   = 4;
  localparam int SPC   = 2;
  localparam int AW    = 8;
  localparam int NPAIR = NSRC;

  logic clk = 0, rst_n = 0;
  logic [2*NSRC*16-1:0] cause = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  irq_id_ctrl #(.NSRC(NSRC), .LAT(LAT), .SPC(SPC), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .src_cause_i(cause), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] exp_id(input int g, input logic [15:0] c);
    return {1'b1, 6'b0, 3'(g / SPC), 6'(g % SPC), c};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = AW'(a);
    @(posedge clk); #1 d = reg_rdata; reg_rd = 0;
  endtask

  task automatic rdchk(input int a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input int g, input logic [15:0] c);
    @(negedge clk); cause[g*16 +: 16] = c;
    @(negedge clk); cause[g*16 +: 16] = '0;
  endtask

  // selector, latency-exact identity, acknowledge
  task automatic svc(input int b, input int i, input logic [31:0] exp);
    wr(3 + b, 32'(1) << i);
    for (int k = 0; k < LAT; k++) rdchk(5 + b, 32'd0, "R5 not yet valid");
    rdchk(5 + b, exp, "R4 identity at latency");
    wr(5 + b, 32'h8000_0000);
    rdchk(5 + b, 32'd0, "R6 ack clears");
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    rdchk(0, 32'd0, "R1 summary");
    rdchk(1, 32'd0, "R1 pending0");
    wr(1, 32'd0);
    rdchk(5, 32'd0, "R1 identity");
    rdchk(3, 32'd0, "R1 selector");
    for (int k = 0; k < NPAIR; k++) begin
      rdchk(64 + k, 32'd0, "R1 enable");
      rdchk(128 + k, 32'hFFFF_FFFF, "R1 mask");
    end
    for (int k = 0; k < NPAIR; k++) begin
      wr(64 + k, 32'hFFFF_FFFF);
      wr(128 + k, 32'd0);
    end

    // R3/R4 sweep over every source of both banks
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NSRC; i++) begin
        int g;
        logic [15:0] c;
        g = b * NSRC + i;
        c = (16'h0101 << (g % 8)) ^ 16'(g);
        pulse(g, c);
        check("R3 irq high", 32'(irq), 32'd1);
        rdchk(0, 32'(1) << b, "R3 summary");
        rdchk(1 + b, 32'(1) << i, "R3 pending");
        svc(b, i, exp_id(g, c));
        wr(1 + b, 32'(1) << i);
        rdchk(1 + b, 32'd0, "R7 served bit cleared");
        wr(1 + b, 32'd0);
        rdchk(0, 32'd0, "R3 summary empty");
      end

    // R2 mask and enable halves
    wr(128, 32'h0000_000F);
    pulse(0, 16'h00FF);
    rdchk(1, 32'd1, "R2 partly masked pending");
    svc(0, 0, exp_id(0, 16'h00F0));
    wr(1, 32'd1);
    wr(128, 32'h0000_00FF);
    pulse(0, 16'h000F);
    rdchk(1, 32'd0, "R2 fully masked");
    wr(1, 32'd0);
    wr(128, 32'd0);
    wr(64, 32'h0000_FFFF);
    pulse(1, 16'h1234);
    rdchk(1, 32'd0, "R2 upper half disabled");
    wr(1, 32'd0);
    wr(64, 32'hFFFF_FFFF);

    // R9 accumulation
    pulse(2, 16'h0003);
    pulse(2, 16'h0300);
    rdchk(1, 32'd4, "R9 pending");
    svc(0, 2, exp_id(2, 16'h0303));
    wr(1, 32'd4);

    // R7 unserved write-back keeps the bit
    pulse(3, 16'h0010);
    rdchk(1, 32'd8, "R7 pending");
    wr(1, 32'd8);
    rdchk(1, 32'd8, "R7 unserved stays");
    svc(0, 3, exp_id(3, 16'h0010));
    wr(1, 32'd8);
    rdchk(1, 32'd0, "R7 cleared after service");
    wr(1, 32'd0);

    // R8 lock and shadow
    rdchk(2, 32'd0, "R8 lock read");
    pulse(4, 16'h0042);
    rdchk(2, 32'd0, "R8 frozen while locked");
    rdchk(0, 32'd0, "R8 summary frozen");
    wr(2, 32'd0);
    rdchk(2, 32'd1, "R8 shadow merged");
    svc(1, 0, exp_id(4, 16'h0042));
    wr(2, 32'd1);

    // R5 invalid selections
    pulse(5, 16'h0055);
    wr(4, 32'd2);
    for (int k = 0; k <= LAT; k++) rdchk(6, 32'd0, "R5 unlocked select");
    rdchk(2, 32'd2, "R5 pending");
    wr(4, 32'd3);
    for (int k = 0; k <= LAT; k++) rdchk(6, 32'd0, "R5 not one-hot");
    wr(4, 32'd1);
    for (int k = 0; k <= LAT; k++) rdchk(6, 32'd0, "R5 not pending");
    svc(1, 1, exp_id(5, 16'h0055));
    wr(2, 32'd2);

    // R10 selector ignored while busy or valid
    pulse(6, 16'h0600);
    pulse(7, 16'h0700);
    rdchk(2, 32'hC, "R10 pending");
    wr(4, 32'd4);
    wr(4, 32'd8);
    for (int k = 0; k < LAT - 1; k++) rdchk(6, 32'd0, "R10 in flight");
    rdchk(6, exp_id(6, 16'h0600), "R10 first selection kept");
    wr(4, 32'd8);
    rdchk(6, exp_id(6, 16'h0600), "R10 valid identity holds");
    wr(6, 32'h8000_0000);
    svc(1, 3, exp_id(7, 16'h0700));
    wr(2, 32'hC);
    rdchk(2, 32'd0, "R10 both cleared");
    wr(2, 32'd0);
    check("R3 irq low", 32'(irq), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule